// File: doc/BRIEF.md
# Header-Inserting Packet Stream Multiplexer

This block gathers several 32-bit streaming sources into one framed output stream. It serves the sources strictly in turn: 0, 1, 2 and so on up to the last channel, then back to 0. Each turn produces one packet, and every packet opens with a header word that the block computes itself.

The header holds the packet ID configured for the serviced channel and a shared 3-bit packet type. Its source coordinate fields are all ones, which encodes -1 for both row and column. An odd-parity bit completes the word. A fixed number of payload words (`PAYLOAD_LEN`) from the chosen source follow the header, and the last of them is flagged with TLAST.

Software or a controlling engine starts a run with a one-cycle `start` pulse and the number of packets to emit. The block raises `done` once the final packet's last word has been accepted downstream, and holds it until the next start. A `start` that arrives while a run is in progress is ignored.

Top module: `pkt_hdr_mux`

## Requirements
- R1: Every header word has the packet ID in bits [4:0], the packet type in bits [14:12], and all ones in source row [20:16] and source column [27:21]. Bits [11:5], [15] and [30:28] are zero. The packet ID is the serviced channel's entry in `cfg_ids` (channel c uses bits [5c+4:5c]).
- R2: Bit 31 of a header makes the number of ones in the full 32-bit word odd. With ID 0 and type 0 the header equals 0x8FFF0000.
- R3: Headers are emitted with `m_tlast` low, and `m_tkeep` is 4'hF on every output word.
- R4: Each header is followed by exactly `PAYLOAD_LEN` payload words. Only the last of them has `m_tlast` high.
- R5: Packets are drawn from channels in ascending order starting at channel 0, and the order wraps after channel `NUM_CH-1`.
- R6: Payload words come only from the serviced channel and are transferred unchanged. Every other channel sees `s_tready` low, and its valid and data have no effect on the output.
- R7: Nothing advances while `m_tready` is low. A pending header holds its value, no source is readied, and a payload word moves only when the serviced channel's valid and `m_tready` are both high.
- R8: After `total_pkts` packets have been emitted, `done` is high, `m_tvalid` is low and all `s_tready` are low. A start with a count of 0 raises `done` one cycle later.
- R9: During and right after reset, `m_tvalid`, `done` and all `s_tready` are low.
- R10: An accepted start clears `done` and restarts the channel order at channel 0, whichever channel the previous run ended on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run start, accepted when no run is in progress |
| total_pkts | input | CNT_W | Number of packets in the run, sampled with `start` |
| cfg_type | input | 3 | Packet type placed in every header |
| cfg_ids | input | NUM_CH*5 | Packet ID per channel, 5 bits each |
| s_tdata | input | NUM_CH*32 | Source data, channel c in bits [32c+31:32c] |
| s_tvalid | input | NUM_CH | Source valid per channel |
| s_tready | output | NUM_CH | Source ready per channel |
| m_tdata | output | 32 | Output data word |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tlast | output | 1 | Last word of a packet |
| m_tkeep | output | 4 | Byte enables, always all ones |
| done | output | 1 | Run complete |

## Verification
The assertions watch the framing on every cycle. They check that a header carries its fixed fields and odd parity and holds steady while stalled, that TLAST falls only on the final payload beat, that at most one source is readied, and that the block stays quiet once `done` is set. Only the bench's scenarios can show that the correct channel is chosen in turn, that the right per-channel ID is used, and that payload words arrive from the right source in order under random valid and ready throttling. They also show that the packet count ends the run and that a new start resets the channel order.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
   localparam int WORD_W = 32;
   localparam int KEEP_W = WORD_W / 8;
   localparam int ID_W   = 5;
   localparam int TYPE_W = 3;
   localparam int ROW_W  = 5;
   localparam int COL_W  = 7;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HDR  = 2'd1,
      SEQ_PAY  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/pkt_hdr_gen.sv
module pkt_hdr_gen
   import pkt_hdr_pkg::*;
#(
   parameter logic [ROW_W-1:0] SRC_ROW    = '1,
   parameter logic [COL_W-1:0] SRC_COL    = '1,
   parameter bit               ODD_PARITY = 1'b1
) (
   input  logic [ID_W-1:0]   pkt_id,
   input  logic [TYPE_W-1:0] pkt_type,
   output logic [WORD_W-1:0] header
);
   logic [WORD_W-2:0] body;

   // layout: zero(3) | column(7) | row(5) | zero(1) | type(3) | zero(7) | id(5)
   assign body = {3'b000, SRC_COL, SRC_ROW, 1'b0, pkt_type, 7'b0000000, pkt_id};

   generate
      if (ODD_PARITY) begin : g_odd
         assign header = {~^body, body};
      end else begin : g_even
         assign header = {^body, body};
      end
   endgenerate
endmodule

// File: rtl/pkt_rr_sel.sv
module pkt_rr_sel #(
   parameter int NUM_CH = 4,
   parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             advance,
   output logic [SEL_W-1:0] sel
);
   logic [SEL_W-1:0] sel_nxt;

   generate
      if (NUM_CH == (1 << SEL_W)) begin : g_pow2
         assign sel_nxt = sel + 1'b1;
      end else begin : g_wrap
         assign sel_nxt = (sel == SEL_W'(NUM_CH - 1)) ? '0 : sel + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       sel <= '0;
      else if (restart) sel <= '0;
      else if (advance) sel <= sel_nxt;
   end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
   import pkt_hdr_pkg::*;
#(
   parameter int PAYLOAD_LEN = 8,
   parameter int CNT_W       = 16,
   parameter int BEAT_W      = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] total,
   input  logic             fire,
   output seq_state_e       state,
   output logic             last_beat,
   output logic             pkt_end,
   output logic             run_start,
   output logic             busy,
   output logic             done
);
   logic [BEAT_W-1:0] beat;
   logic [CNT_W-1:0]  sent;
   logic [CNT_W-1:0]  target;
   logic              final_pkt;

   assign run_start = (state == SEQ_IDLE) && start;
   assign busy      = (state != SEQ_IDLE);
   assign last_beat = (beat == BEAT_W'(PAYLOAD_LEN - 1));
   assign pkt_end   = (state == SEQ_PAY) && fire && last_beat;
   assign final_pkt = ((sent + 1'b1) == target);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         beat   <= '0;
         sent   <= '0;
         target <= '0;
         done   <= 1'b0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  target <= total;
                  sent   <= '0;
                  beat   <= '0;
                  if (total == '0) begin
                     done <= 1'b1;
                  end else begin
                     done  <= 1'b0;
                     state <= SEQ_HDR;
                  end
               end
            end
            SEQ_HDR: begin
               if (fire) begin
                  beat  <= '0;
                  state <= SEQ_PAY;
               end
            end
            SEQ_PAY: begin
               if (fire) begin
                  if (last_beat) begin
                     beat <= '0;
                     sent <= sent + 1'b1;
                     if (final_pkt) begin
                        done  <= 1'b1;
                        state <= SEQ_IDLE;
                     end else begin
                        state <= SEQ_HDR;
                     end
                  end else begin
                     beat <= beat + 1'b1;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pkt_hdr_mux.sv
module pkt_hdr_mux
   import pkt_hdr_pkg::*;
#(
   parameter int               NUM_CH      = 4,
   parameter int               PAYLOAD_LEN = 8,
   parameter int               CNT_W       = 16,
   parameter logic [ROW_W-1:0] SRC_ROW     = '1,
   parameter logic [COL_W-1:0] SRC_COL     = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [CNT_W-1:0]         total_pkts,
   input  logic [TYPE_W-1:0]        cfg_type,
   input  logic [NUM_CH*ID_W-1:0]   cfg_ids,
   input  logic [NUM_CH*WORD_W-1:0] s_tdata,
   input  logic [NUM_CH-1:0]        s_tvalid,
   output logic [NUM_CH-1:0]        s_tready,
   output logic [WORD_W-1:0]        m_tdata,
   output logic                     m_tvalid,
   input  logic                     m_tready,
   output logic                     m_tlast,
   output logic [KEEP_W-1:0]        m_tkeep,
   output logic                     done
);
   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("pkt_hdr_mux: NUM_CH must lie in 1..32");
      end
      if (PAYLOAD_LEN < 1) begin : g_bad_len
         $error("pkt_hdr_mux: PAYLOAD_LEN must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("pkt_hdr_mux: CNT_W must be at least 1");
      end
   endgenerate

   seq_state_e        seq_state;
   logic              last_beat;
   logic              pkt_end;
   logic              run_start;
   logic              seq_busy;
   logic              fire;
   logic [SEL_W-1:0]  sel;
   logic [WORD_W-1:0] header;
   logic [WORD_W-1:0] ch_data [NUM_CH];
   logic [ID_W-1:0]   ch_id   [NUM_CH];
   logic              in_pay;

   assign in_pay = (seq_state == SEQ_PAY);

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         assign ch_data[g]  = s_tdata[g*WORD_W +: WORD_W];
         assign ch_id[g]    = cfg_ids[g*ID_W +: ID_W];
         assign s_tready[g] = in_pay && (sel == SEL_W'(g)) && m_tready;
      end
   endgenerate

   pkt_seq #(
      .PAYLOAD_LEN (PAYLOAD_LEN),
      .CNT_W       (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .total     (total_pkts),
      .fire      (fire),
      .state     (seq_state),
      .last_beat (last_beat),
      .pkt_end   (pkt_end),
      .run_start (run_start),
      .busy      (seq_busy),
      .done      (done)
   );

   pkt_rr_sel #(
      .NUM_CH (NUM_CH),
      .SEL_W  (SEL_W)
   ) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (run_start),
      .advance (pkt_end),
      .sel     (sel)
   );

   pkt_hdr_gen #(
      .SRC_ROW    (SRC_ROW),
      .SRC_COL    (SRC_COL),
      .ODD_PARITY (1'b1)
   ) u_hdr (
      .pkt_id   (ch_id[sel]),
      .pkt_type (cfg_type),
      .header   (header)
   );

   always_comb begin
      m_tvalid = 1'b0;
      m_tdata  = '0;
      m_tlast  = 1'b0;
      unique case (seq_state)
         SEQ_HDR: begin
            m_tvalid = 1'b1;
            m_tdata  = header;
         end
         SEQ_PAY: begin
            m_tvalid = s_tvalid[sel];
            m_tdata  = ch_data[sel];
            m_tlast  = last_beat;
         end
         default: ;
      endcase
   end

   assign m_tkeep = '1;
   assign fire    = m_tvalid && m_tready;
endmodule

// File: rtl/pkt_hdr_mux_chk.sv
module pkt_hdr_mux_chk #(
   parameter int NUM_CH      = 4,
   parameter int PAYLOAD_LEN = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic [31:0]       m_tdata,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic              m_tlast,
   input logic [3:0]        m_tkeep,
   input logic [NUM_CH-1:0] s_tready,
   input logic              done
);
   localparam int PH_W = $clog2(PAYLOAD_LEN + 1);

   // word position within the current packet, counted from output handshakes
   logic [PH_W-1:0] ph;
   logic            hdr_ph;

   always_ff @(posedge clk) begin
      if (!rst_n)                   ph <= '0;
      else if (start && !busy)      ph <= '0;
      else if (m_tvalid && m_tready) ph <= (ph == PH_W'(PAYLOAD_LEN)) ? '0 : ph + 1'b1;
   end

   assign hdr_ph = (ph == '0);

   assert_hdr_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && hdr_ph) |-> (m_tdata[27:16] == 12'hFFF && m_tdata[30:28] == 3'b000
                                && m_tdata[15] == 1'b0 && m_tdata[11:5] == 7'd0));

   assert_hdr_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && hdr_ph) |-> ($countones(m_tdata) % 2 == 1));

   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tkeep == 4'hF));

   assert_hdr_nolast_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && hdr_ph) |-> !m_tlast);

   assert_final_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && ph == PH_W'(PAYLOAD_LEN)) |-> m_tlast);

   assert_mid_nolast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && ph != PH_W'(PAYLOAD_LEN)) |-> !m_tlast);

   assert_one_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_tready));

   assert_hdr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && hdr_ph && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

   assert_stall_noready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !m_tready |-> (s_tready == '0));

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!m_tvalid && s_tready == '0));
endmodule

bind pkt_hdr_mux pkt_hdr_mux_chk #(
   .NUM_CH      (NUM_CH),
   .PAYLOAD_LEN (PAYLOAD_LEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (seq_busy),
   .m_tdata  (m_tdata),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .m_tlast  (m_tlast),
   .m_tkeep  (m_tkeep),
   .s_tready (s_tready),
   .done     (done)
);

// File: tb/pkt_hdr_mux_bench.sv
`timescale 1ns/1ps
module pkt_hdr_mux_bench;
   localparam int NUM_CH      = 4;
   localparam int PAYLOAD_LEN = 8;
   localparam int CNT_W       = 16;
   localparam int N_VEC       = 6;
   // fields: total[31:24] type[23:16] ready_throttle[15:8] valid_throttle[7:0]
   localparam logic [31:0] VEC_TBL [N_VEC] = '{
      32'h03_05_00_00, 32'h04_02_00_00, 32'h09_07_04_00,
      32'h06_01_00_06, 32'h0B_03_08_08, 32'h05_06_0C_03
   };

   logic                     clk = 1'b0;
   logic                     rst_n;
   logic                     start;
   logic [CNT_W-1:0]         total_pkts;
   logic [2:0]               cfg_type;
   logic [NUM_CH*5-1:0]      cfg_ids;
   logic [NUM_CH*32-1:0]     s_tdata;
   logic [NUM_CH-1:0]        s_tvalid;
   logic [NUM_CH-1:0]        s_tready;
   logic [31:0]              m_tdata;
   logic                     m_tvalid;
   logic                     m_tready;
   logic                     m_tlast;
   logic [3:0]               m_tkeep;
   logic                     done;

   always #2.5 clk = ~clk;

   pkt_hdr_mux #(
      .NUM_CH      (NUM_CH),
      .PAYLOAD_LEN (PAYLOAD_LEN),
      .CNT_W       (CNT_W)
   ) u_pkt_hdr_mux (
      .clk (clk), .rst_n (rst_n), .start (start), .total_pkts (total_pkts),
      .cfg_type (cfg_type), .cfg_ids (cfg_ids), .s_tdata (s_tdata),
      .s_tvalid (s_tvalid), .s_tready (s_tready), .m_tdata (m_tdata),
      .m_tvalid (m_tvalid), .m_tready (m_tready), .m_tlast (m_tlast),
      .m_tkeep (m_tkeep), .done (done)
   );

   // source models: each channel emits {channel, 0x00, running word count}
   logic        src_clr;
   logic [15:0] src_cnt [NUM_CH];

   always_ff @(posedge clk) begin
      for (int c = 0; c < NUM_CH; c++) begin
         if (src_clr)                        src_cnt[c] <= '0;
         else if (s_tvalid[c] && s_tready[c]) src_cnt[c] <= src_cnt[c] + 16'd1;
      end
   end

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         s_tdata[c*32 +: 32] = {8'(c), 8'h00, src_cnt[c]};
         cfg_ids[c*5 +: 5]   = 5'(c * 5);
      end
   end

   int          n_vec  = 0;
   int          n_fail = 0;
   int          exp_pkt, exp_word;
   int          exp_cnt [NUM_CH];
   int          rthr, vthr;
   logic [31:0] lfsr;

   function automatic logic [31:0] hdr_model(int ch, logic [2:0] t);
      logic [31:0] h;
      h        = '0;
      h[4:0]   = 5'(ch * 5);
      h[14:12] = t;
      h[20:16] = 5'h1F;
      h[27:21] = 7'h7F;
      h[31]    = ~^h[30:0];
      return h;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
   endtask

   task automatic step();
      @(negedge clk);
      m_tready = (int'(lfsr[3:0]) >= rthr);
      for (int c = 0; c < NUM_CH; c++)
         s_tvalid[c] = (int'((lfsr >> (4 + 4*c)) & 32'hF) >= vthr);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      #1;
      if (m_tvalid && m_tready) begin
         int               ch;
         logic [31:0]      exp_d;
         logic             exp_l;
         logic [NUM_CH-1:0] exp_r;
         ch = exp_pkt % NUM_CH;  // R5: channel order 0,1,2,3,0,...
         if (exp_word == 0) begin
            exp_d = hdr_model(ch, cfg_type);
            exp_l = 1'b0;
            exp_r = '0;
         end else begin
            exp_d = {8'(ch), 8'h00, 16'(exp_cnt[ch])};
            exp_l = (exp_word == PAYLOAD_LEN);
            exp_r = NUM_CH'(1) << ch;
            exp_cnt[ch]++;
         end
         check(m_tdata == exp_d && m_tlast == exp_l && m_tkeep == 4'hF && s_tready == exp_r,
               (exp_word == 0) ? "R1/R2/R3/R5 header word" :
               (exp_l ? "R4 last payload word" : "R6 payload word"),
               m_tdata, exp_d);
         if (exp_word == PAYLOAD_LEN) begin
            exp_word = 0;
            exp_pkt++;
         end else begin
            exp_word++;
         end
      end
   endtask

   task automatic run_begin(input int total, input logic [2:0] t);
      @(negedge clk);
      cfg_type   = t;
      total_pkts = CNT_W'(total);
      start      = 1'b1;
      src_clr    = 1'b1;
      m_tready   = 1'b0;
      s_tvalid   = '0;
      @(negedge clk);
      start    = 1'b0;
      src_clr  = 1'b0;
      exp_pkt  = 0;
      exp_word = 0;
      for (int c = 0; c < NUM_CH; c++) exp_cnt[c] = 0;
      #1;
   endtask

   task automatic drain(input int total);
      for (int k = 0; k < 20000; k++) begin
         step();
         if (done) break;
      end
      check(exp_pkt == total && exp_word == 0, "R8 packet count", 32'(exp_pkt), 32'(total));
      check(done && !m_tvalid && s_tready == '0, "R8 idle after run",
            {29'd0, done, m_tvalid, |s_tready}, 32'h4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      start      = 1'b0;
      src_clr    = 1'b1;
      total_pkts = '0;
      cfg_type   = '0;
      m_tready   = 1'b0;
      s_tvalid   = '0;
      lfsr       = 32'hACE1_1234;
      rthr       = 0;
      vthr       = 0;
      repeat (3) @(negedge clk);
      #1;
      check(!m_tvalid && !done && s_tready == '0, "R9 in reset",
            {29'd0, m_tvalid, done, |s_tready}, 32'h0);
      @(negedge clk);
      rst_n   = 1'b1;
      src_clr = 1'b0;
      @(negedge clk);
      #1;
      check(!m_tvalid && !done && s_tready == '0, "R9 after reset",
            {29'd0, m_tvalid, done, |s_tready}, 32'h0);

      // R2 literal header and R7 stall on a pending header
      run_begin(1, 3'd0);
      check(m_tvalid && m_tdata == 32'h8FFF_0000, "R2 header value", m_tdata, 32'h8FFF_0000);
      rthr = 16;
      for (int k = 0; k < 4; k++) begin
         step();
         check(m_tvalid && m_tdata == 32'h8FFF_0000 && s_tready == '0, "R7 header held",
               m_tdata, 32'h8FFF_0000);
      end
      rthr = 0;
      drain(1);

      // table of runs with varied counts, types and throttling
      for (int v = 0; v < N_VEC; v++) begin
         rthr = int'(VEC_TBL[v][15:8]);
         vthr = int'(VEC_TBL[v][7:0]);
         run_begin(int'(VEC_TBL[v][31:24]), VEC_TBL[v][18:16]);
         drain(int'(VEC_TBL[v][31:24]));
      end

      // R10: previous run ended after channel 0 of a 5-packet run; restart from channel 0
      rthr = 0;
      vthr = 0;
      run_begin(2, 3'd4);
      check(!done && m_tvalid && m_tdata == hdr_model(0, 3'd4), "R10 restart at channel 0",
            m_tdata, hdr_model(0, 3'd4));
      drain(2);

      // R8: zero-length run
      run_begin(0, 3'd1);
      check(done && !m_tvalid && s_tready == '0, "R8 zero count",
            {29'd0, done, m_tvalid, |s_tready}, 32'h4);

      summary();
      $finish;
   end
endmodule